// File: doc/BRIEF.md
# PCI Read Request Translator

This block sits between a processor-side bus master and a PCI initiator engine. It takes one read request at a time and turns it into a PCI command code plus a sequence of 32-bit data-phase addresses, each with its own 4-bit byte-enable nibble. A request may be a single transfer, a burst of whole 64-bit double words, or a cache-line transfer. Every request names an address-space class: I/O, prefetchable memory or non-prefetchable memory.

The command is chosen from the transfer kind and the space class together. Combinations the PCI side cannot serve are refused with a one-cycle error pulse, and no PCI activity follows. Line requests are moved back to the start of their line. After that, the address moves up by 4 bytes each time the PCI side takes a data phase. A response timer, frozen while the requester signals wait, ends a stalled transfer and reports a timeout.

Top module: `pcib_rd_xlate`

## Requirements
- R1: `req_ready` is high exactly when no transfer is active. A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_valid` during an active transfer has no effect.
- R2: Any legal request to I/O space (`req_space`=0) is issued with command 4'b0010, whatever the transfer kind.
- R3: A legal request to prefetchable memory (`req_space`=1) is issued as 4'b0110 for a single transfer (`req_kind`=0), 4'b1100 for a burst (`req_kind`=1) and 4'b1110 for a line (`req_kind`=2).
- R4: A request to non-prefetchable memory (`req_space`=2) is refused for every kind. `req_err` pulses for one cycle in the cycle after acceptance, and `cmd_valid` stays low.
- R5: A burst or line whose `req_be` is not 8'hFF is refused like R4. The same holds for a burst with `req_len`=0, a line with `req_line`=3, a single transfer with `req_be`=0, and `req_kind`=3 or `req_space`=3.
- R6: A single transfer uses the 8-byte-aligned address. If only `req_be[7:4]` is nonzero, it runs one phase at aligned+4 with nibble `req_be[7:4]`. If only `req_be[3:0]` is nonzero, it runs one phase at aligned+0 with nibble `req_be[3:0]`. If both are nonzero, it runs two phases: the low nibble at aligned+0, then the high nibble at aligned+4.
- R7: A line starts at the address aligned down to the line size: 16, 32 or 64 bytes for `req_line` 0, 1 or 2. A burst starts at the address aligned down to 8 bytes. Bursts and lines drive `phase_be`=4'hF.
- R8: `phase_addr` moves up by 4 after each cycle with `pci_ack` high, and holds in cycles without it.
- R9: A burst runs 2×`req_len` phases and a line runs 4, 8 or 16 phases. `done` pulses for one cycle right after the cycle that acknowledges the last phase, and the block is idle in that cycle.
- R10: While a transfer is active, the timer counts cycles that have neither `pci_ack` nor `req_wait`. An acknowledge clears it, and wait holds it. When the count reaches `TMO_LIM`, `timeout` pulses for one cycle and the block goes idle.
- R11: During and after reset, the block is idle: `req_ready` is 1, and `cmd_valid`, `req_err`, `done` and `timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_kind | input | 2 | 0 single, 1 burst, 2 line |
| req_space | input | 2 | 0 I/O, 1 prefetchable memory, 2 non-prefetchable memory |
| req_addr | input | 32 | Byte address of the request |
| req_be | input | 8 | Byte enables over one 64-bit double word |
| req_len | input | LEN_W | Burst length in double words |
| req_line | input | 2 | Line size code: 0 = 4, 1 = 8, 2 = 16 words |
| req_wait | input | 1 | Requester wait; freezes the response timer |
| req_err | output | 1 | One-cycle pulse: request refused |
| pci_ack | input | 1 | PCI side takes the current data phase |
| cmd_valid | output | 1 | Transfer active; command and phase outputs valid |
| cmd_code | output | 4 | PCI command code |
| phase_addr | output | 32 | Address of the current data phase |
| phase_be | output | 4 | Byte enables of the current data phase |
| done | output | 1 | One-cycle pulse after the last phase |
| timeout | output | 1 | One-cycle pulse when the response timer expires |

## Verification
Corrupted sequencer state appears at the ports within one clock. A wrong phase counter either drops `cmd_valid` and pulses `done` too early, or keeps the transfer running past the expected `done` cycle. An address register that slips shows a `phase_addr` off by a multiple of 4 at the next acknowledged phase. A decode fault shows as a wrong `cmd_code` or a misaligned first address in the first active cycle, or as a `req_err` pulse that is missing or out of place. A timer that counts during wait, or misses a clear, moves the `timeout` pulse away from the cycle the reference model predicts.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam logic [1:0] KIND_SINGLE = 2'd0;
  localparam logic [1:0] KIND_BURST  = 2'd1;
  localparam logic [1:0] KIND_LINE   = 2'd2;

  localparam logic [1:0] SPACE_IO      = 2'd0;
  localparam logic [1:0] SPACE_PREF    = 2'd1;
  localparam logic [1:0] SPACE_NONPREF = 2'd2;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] start;
    logic [7:0]  be8;
  } xfer_t;
endpackage

// File: rtl/pcib_req_decode.sv
module pcib_req_decode
  import pcib_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PH_W  = 9
) (
  input  logic [1:0]       kind,
  input  logic [1:0]       space,
  input  logic [31:0]      addr,
  input  logic [7:0]       be,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       line_sz,
  output logic             ok,
  output xfer_t            xf,
  output logic [PH_W-1:0]  phases
);
  logic lo_used, hi_used, shape_ok, space_ok;
  logic [31:0] dw_base;

  always_comb begin
    lo_used  = |be[3:0];
    hi_used  = |be[7:4];
    dw_base  = addr & ~32'h7;
    shape_ok = 1'b0;
    xf       = '0;
    phases   = '0;
    unique case (kind)
      KIND_SINGLE: begin
        shape_ok = lo_used | hi_used;
        xf.be8   = be;
        xf.start = lo_used ? dw_base : (dw_base | 32'h4);
        phases   = (lo_used && hi_used) ? PH_W'(2) : PH_W'(1);
      end
      KIND_BURST: begin
        shape_ok = (&be) && (len != '0);
        xf.be8   = 8'hFF;
        xf.start = dw_base;
        phases   = PH_W'({len, 1'b0});
      end
      KIND_LINE: begin
        shape_ok = (&be) && (line_sz != 2'd3);
        xf.be8   = 8'hFF;
        case (line_sz)
          2'd0:    begin xf.start = addr & ~32'hF;  phases = PH_W'(4);  end
          2'd1:    begin xf.start = addr & ~32'h1F; phases = PH_W'(8);  end
          default: begin xf.start = addr & ~32'h3F; phases = PH_W'(16); end
        endcase
      end
      default: shape_ok = 1'b0;
    endcase

    space_ok = 1'b1;
    case (space)
      SPACE_IO:   xf.cmd = CMD_IO_RD;
      SPACE_PREF: xf.cmd = (kind == KIND_SINGLE) ? CMD_MEM_RD :
                           (kind == KIND_BURST)  ? CMD_MEM_RDM : CMD_MEM_RDL;
      default: begin
        xf.cmd   = CMD_IO_RD;
        space_ok = 1'b0;
      end
    endcase
    ok = shape_ok && space_ok;
  end
endmodule

// File: rtl/pcib_resp_timer.sv
module pcib_resp_timer #(
  parameter int TMO_LIM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  input  logic hold,
  output logic expire
);
  localparam int TMO_W = $clog2(TMO_LIM + 1);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = run && !ack && !hold && (cnt_q == TMO_W'(TMO_LIM - 1));

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!run || ack || expire) begin
      cnt_d = '0;
    end else if (hold) begin
      cnt_en = 1'b0;
    end else begin
      cnt_d = cnt_q + TMO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pcib_xfer_seq.sv
module pcib_xfer_seq
  import pcib_pkg::*;
#(
  parameter int PH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  xfer_t           xf,
  input  logic [PH_W-1:0] phases,
  input  logic            ack,
  input  logic            expire,
  output logic            busy,
  output logic [3:0]      cmd,
  output logic [31:0]     addr,
  output logic [3:0]      be,
  output logic            done,
  output logic            tmo
);
  logic            busy_q, busy_d;
  logic [31:0]     addr_q, addr_d;
  logic [PH_W-1:0] left_q, left_d;
  logic [3:0]      cmd_q, cmd_d;
  logic [7:0]      be_q, be_d;
  logic            done_q, done_d, tmo_q, tmo_d;
  logic            load_en;

  always_comb begin
    busy_d  = busy_q;
    addr_d  = addr_q;
    left_d  = left_q;
    cmd_d   = cmd_q;
    be_d    = be_q;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    load_en = 1'b0;
    if (!busy_q) begin
      if (start) begin
        load_en = 1'b1;
        busy_d  = 1'b1;
        addr_d  = xf.start;
        left_d  = phases;
        cmd_d   = xf.cmd;
        be_d    = xf.be8;
      end
    end else if (ack) begin
      load_en = 1'b1;
      if (left_q == PH_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        addr_d = addr_q + 32'd4;
        left_d = left_q - PH_W'(1);
      end
    end else if (expire) begin
      busy_d = 1'b0;
      tmo_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      cmd_q  <= '0;
      be_q   <= '0;
    end else if (load_en) begin
      addr_q <= addr_d;
      left_q <= left_d;
      cmd_q  <= cmd_d;
      be_q   <= be_d;
    end
  end

  assign busy = busy_q;
  assign cmd  = cmd_q;
  assign addr = addr_q;
  assign be   = addr_q[2] ? be_q[7:4] : be_q[3:0];
  assign done = done_q;
  assign tmo  = tmo_q;
endmodule

// File: rtl/pcib_rd_xlate.sv
module pcib_rd_xlate
  import pcib_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int TMO_LIM = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_space,
  input  logic [31:0]      req_addr,
  input  logic [7:0]       req_be,
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       req_line,
  input  logic             req_wait,
  output logic             req_err,
  input  logic             pci_ack,
  output logic             cmd_valid,
  output logic [3:0]       cmd_code,
  output logic [31:0]      phase_addr,
  output logic [3:0]       phase_be,
  output logic             done,
  output logic             timeout
);
  localparam int PH_W = (LEN_W + 1 > 5) ? LEN_W + 1 : 5;

  logic            dec_ok, accept, busy, expire;
  logic            err_q, err_d;
  xfer_t           dec_xf;
  logic [PH_W-1:0] dec_phases;

  pcib_req_decode #(.LEN_W(LEN_W), .PH_W(PH_W)) u_dec (
    .kind(req_kind), .space(req_space), .addr(req_addr), .be(req_be),
    .len(req_len), .line_sz(req_line),
    .ok(dec_ok), .xf(dec_xf), .phases(dec_phases)
  );

  pcib_resp_timer #(.TMO_LIM(TMO_LIM)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(busy), .ack(pci_ack), .hold(req_wait),
    .expire(expire)
  );

  pcib_xfer_seq #(.PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && dec_ok), .xf(dec_xf),
    .phases(dec_phases), .ack(pci_ack), .expire(expire),
    .busy(busy), .cmd(cmd_code), .addr(phase_addr), .be(phase_be),
    .done(done), .tmo(timeout)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign err_d     = accept && !dec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign req_err   = err_q;
  assign cmd_valid = busy;
endmodule

// File: rtl/pcib_rd_xlate_chk.sv
module pcib_rd_xlate_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_kind,
  input logic [1:0]       req_space,
  input logic [31:0]      req_addr,
  input logic [7:0]       req_be,
  input logic [LEN_W-1:0] req_len,
  input logic [1:0]       req_line,
  input logic             req_wait,
  input logic             req_err,
  input logic             pci_ack,
  input logic             cmd_valid,
  input logic [3:0]       cmd_code,
  input logic [31:0]      phase_addr,
  input logic [3:0]       phase_be,
  input logic             done,
  input logic             timeout
);
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  a_r3_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code == 4'b0010 || cmd_code == 4'b0110 ||
                   cmd_code == 4'b1100 || cmd_code == 4'b1110));

  a_r4_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!cmd_valid && $past(req_valid && req_ready)));

  a_r7_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_code == 4'b1110) |-> (phase_addr[3:0] == 4'd0));

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(cmd_valid && pci_ack)) |-> (phase_addr == $past(phase_addr) + 32'd4));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(cmd_valid && !pci_ack)) |-> $stable(phase_addr));

  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cmd_valid && pci_ack) && !timeout));

  a_r10_wait_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> ($past(!req_wait && !pci_ack && cmd_valid) && !cmd_valid));
endmodule

bind pcib_rd_xlate pcib_rd_xlate_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/pcib_rd_xlate_test.sv
module pcib_rd_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;
  localparam int TMO        = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_wait, req_err, pci_ack;
  logic [1:0] req_kind, req_space, req_line;
  logic [31:0] req_addr;
  logic [7:0] req_be;
  logic [LEN_W-1:0] req_len;
  logic cmd_valid, done, timeout;
  logic [3:0] cmd_code, phase_be;
  logic [31:0] phase_addr;

  int n_checks = 0, n_fail = 0;
  int n_done = 0, n_err = 0, n_tmo = 0;

  pcib_rd_xlate #(.LEN_W(LEN_W), .TMO_LIM(TMO)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_busy, m_err, m_done, m_tmo;
  logic [31:0] m_addr;
  logic [3:0]  m_cmd;
  logic [7:0]  m_be;
  int          m_left, m_cnt;

  function automatic bit mdec(input int kind, input int space, input logic [31:0] a,
                              input logic [7:0] be, input int len, input int lsz,
                              output logic [3:0] cmd, output logic [31:0] st,
                              output int n, output logic [7:0] bq);
    bit good = 1;
    int words;
    cmd = 4'h0; st = 0; n = 0; bq = 8'hFF;
    if (space == 0) cmd = 4'b0010;
    else if (space == 1) cmd = (kind == 0) ? 4'b0110 : (kind == 1) ? 4'b1100 : 4'b1110;
    else good = 0;
    if (kind == 0) begin
      if (be == 0) good = 0;
      bq = be;
      st = a - (a % 8) + ((be[3:0] == 0) ? 4 : 0);
      n  = (be[3:0] != 0 && be[7:4] != 0) ? 2 : 1;
    end else if (kind == 1) begin
      if (be != 8'hFF || len == 0) good = 0;
      st = a - (a % 8);
      n  = 2 * len;
    end else if (kind == 2) begin
      if (be != 8'hFF || lsz == 3) good = 0;
      words = 4 << lsz;
      st = a - (a % (words * 4));
      n  = words;
    end else good = 0;
    return good;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_done = 0; m_tmo = 0; m_cnt = 0; m_left = 0;
    end else begin
      m_err = 0; m_done = 0; m_tmo = 0;
      if (!m_busy) begin
        if (req_valid) begin
          logic [3:0] c; logic [31:0] s; int n; logic [7:0] b;
          if (mdec(int'(req_kind), int'(req_space), req_addr, req_be, int'(req_len),
                   int'(req_line), c, s, n, b)) begin
            m_busy = 1; m_cmd = c; m_addr = s; m_left = n; m_be = b; m_cnt = 0;
          end else m_err = 1;
        end
      end else if (pci_ack) begin
        m_cnt = 0;
        if (m_left == 1) begin m_busy = 0; m_done = 1; end
        else begin m_left--; m_addr = m_addr + 4; end
      end else if (!req_wait) begin
        m_cnt++;
        if (m_cnt == TMO) begin m_busy = 0; m_tmo = 1; m_cnt = 0; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 req_ready", {31'b0, req_ready}, {31'b0, !m_busy});
      chk("R1 cmd_valid", {31'b0, cmd_valid}, {31'b0, m_busy});
      chk("R4 req_err", {31'b0, req_err}, {31'b0, m_err});
      chk("R9 done", {31'b0, done}, {31'b0, m_done});
      chk("R10 timeout", {31'b0, timeout}, {31'b0, m_tmo});
      if (m_busy) begin
        chk("R2/R3 cmd_code", {28'b0, cmd_code}, {28'b0, m_cmd});
        chk("R8 phase_addr", phase_addr, m_addr);
        chk("R6 phase_be", {28'b0, phase_be},
            {28'b0, (m_addr[2] ? m_be[7:4] : m_be[3:0])});
      end
      n_done += done; n_err += req_err; n_tmo += timeout;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input int k, input int s, input logic [31:0] a, input logic [7:0] be,
                       input int len, input int lsz);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = 2'(k); req_space = 2'(s); req_addr = a; req_be = be;
    req_len = LEN_W'(len); req_line = 2'(lsz); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // mode 0 no ack, 1 ack every cycle, 2 ack every other cycle
  task automatic serve(input int mode, output int cyc);
    cyc = 0;
    while (cmd_valid && cyc < 300) begin
      pci_ack = (mode == 1) || (mode == 2 && cyc % 2 == 1);
      @(negedge clk);
      cyc++;
    end
    pci_ack = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; req_valid = 0; req_wait = 0; pci_ack = 0;
    req_kind = 0; req_space = 0; req_addr = 0; req_be = 0; req_len = 0; req_line = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R11 idle in reset", {28'b0, cmd_valid, req_err, done, timeout}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", {31'b0, req_ready}, 32'd1);

    // R2 single I/O, low half
    issue(0, 0, 32'h0000_1003, 8'h0F, 0, 0);
    chk("R2 io cmd", {28'b0, cmd_code}, 32'h2);
    chk("R6 low half addr", phase_addr, 32'h0000_1000);
    serve(1, cyc);
    // R3/R6 single prefetchable, high half only
    issue(0, 1, 32'h0000_2001, 8'hF0, 0, 0);
    chk("R3 mem read", {28'b0, cmd_code}, 32'h6);
    chk("R6 high half addr", phase_addr, 32'h0000_2004);
    serve(1, cyc);
    // R6 two-phase single
    issue(0, 1, 32'h0000_2006, 8'h3C, 0, 0);
    chk("R6 split nibble0", {28'b0, phase_be}, 32'hC);
    serve(1, cyc);
    chk("R9 split phases", cyc, 2);
    // R3/R9 burst prefetchable, alternate acks
    issue(1, 1, 32'h0000_300C, 8'hFF, 3, 0);
    chk("R3 mem read multiple", {28'b0, cmd_code}, 32'hC);
    chk("R7 burst start", phase_addr, 32'h0000_3008);
    serve(2, cyc);
    chk("R9 burst cycles", cyc, 12);
    // R2 burst to I/O
    issue(1, 0, 32'h0000_0010, 8'hFF, 1, 0);
    chk("R2 io burst cmd", {28'b0, cmd_code}, 32'h2);
    serve(1, cyc);
    chk("R9 io burst phases", cyc, 2);
    // R7 lines
    issue(2, 1, 32'h0000_4014, 8'hFF, 0, 1);
    chk("R3 mem read line", {28'b0, cmd_code}, 32'hE);
    chk("R7 line8 start", phase_addr, 32'h0000_4000);
    serve(1, cyc);
    chk("R9 line8 phases", cyc, 8);
    issue(2, 1, 32'h0000_407C, 8'hFF, 0, 2);
    chk("R7 line16 start", phase_addr, 32'h0000_4040);
    serve(2, cyc);
    chk("R9 line16 cycles", cyc, 32);
    issue(2, 0, 32'h0000_5008, 8'hFF, 0, 0);
    chk("R7 line4 start", phase_addr, 32'h0000_5000);
    serve(1, cyc);
    // R4/R5 refusals
    issue(0, 2, 32'h0000_6000, 8'h0F, 0, 0);
    chk("R4 nonpref refused", {31'b0, req_err}, 32'd1);
    issue(1, 2, 32'h0000_6000, 8'hFF, 2, 0);
    issue(2, 2, 32'h0000_6000, 8'hFF, 0, 0);
    issue(1, 1, 32'h0000_6000, 8'h7F, 2, 0);
    chk("R5 partial be burst", {30'b0, req_err, cmd_valid}, 32'd2);
    issue(2, 1, 32'h0000_6000, 8'hEF, 0, 0);
    issue(1, 1, 32'h0000_6000, 8'hFF, 0, 0);
    issue(2, 1, 32'h0000_6000, 8'hFF, 0, 3);
    issue(0, 1, 32'h0000_6000, 8'h00, 0, 0);
    issue(3, 1, 32'h0000_6000, 8'hFF, 1, 0);
    issue(0, 3, 32'h0000_6000, 8'h0F, 0, 0);
    @(negedge clk);
    chk("R5 still idle", {31'b0, cmd_valid}, 32'd0);
    // R1 request during a transfer is ignored
    issue(1, 1, 32'h0000_7000, 8'hFF, 2, 0);
    pci_ack = 1'b1;
    @(negedge clk);
    req_kind = 0; req_space = 0; req_addr = 32'h0000_9000; req_be = 8'h0F; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy addr unaffected", phase_addr, 32'h0000_7008);
    serve(1, cyc);
    chk("R1 ignored request ended", cyc, 2);
    @(negedge clk);
    chk("R1 no late start", {31'b0, cmd_valid}, 32'd0);
    // R10 timeout with wait freeze
    issue(1, 1, 32'h0000_8000, 8'hFF, 4, 0);
    req_wait = 1'b1;
    repeat (3 * TMO) @(negedge clk);
    chk("R10 held during wait", {31'b0, cmd_valid}, 32'd1);
    req_wait = 1'b0;
    pci_ack = 1'b1;
    @(negedge clk);
    pci_ack = 1'b0;
    chk("R8 ack steps addr", phase_addr, 32'h0000_8004);
    serve(0, cyc);
    chk("R10 timeout delay", cyc, TMO);
    chk("R10 timeout pulse", {31'b0, timeout}, 32'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", {31'b0, timeout}, 32'd0);
    // event totals
    chk("R9 done count", n_done, 9);
    chk("R4 err count", n_err, 10);
    chk("R10 timeout count", n_tmo, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule